// File: doc/BRIEF.md
# Parallel Flash Program and Erase Controller

This block sits on the host side of a 16-bit parallel NOR flash bus and turns one request (program one word, erase one 2K-word sector, or erase the whole array) into the unlock and command writes the flash expects. Each bus write is built from counted phases: chip enable low for a setup time, then a write strobe for a pulse width, then a hold time. After the final command write, the controller reads the status bit DQ6 again and again until it stops toggling.

Completion can happen between two status reads, so two equal DQ6 reads do not end the operation on their own. The controller takes two more reads, and only when both match is the operation treated as finished. If DQ6 toggles again, polling resumes. A program then waits a settle interval and reads the target word back for comparison. If polling runs past a cycle limit, the request ends in an error. Requests arrive one at a time over a valid/ready handshake.

Top module: `flashc_top`

## Requirements
- R1: Opcode 0 (program) produces exactly four bus writes, in this order: 00AAh to 5555h, 0055h to 2AAAh, 00A0h to 5555h, then the request data to the request address.
- R2: Opcode 1 (sector erase) produces six writes: 00AAh to 5555h, 0055h to 2AAAh, 0080h to 5555h, 00AAh to 5555h, 0055h to 2AAAh, and finally 0030h to an address that keeps request address bits 15..11 and clears bits 10..0.
- R3: Opcode 2 (chip erase) produces the same first five writes as R2. The sixth write is 0010h to 5555h. Opcode 3 behaves as opcode 2.
- R4: During every bus write, CE# is low for exactly T_SETUP cycles before WE# falls. WE# then stays low for exactly T_PULSE cycles, with CE# low and OE# high. The data bus is driven for the whole time WE# is low.
- R5: No status read (OE# low) starts before the last command write of the request has completed.
- R6: `done` is reported only after two consecutive DQ6 reads are equal and the next two reads also show that same value. If a confirming read differs, polling resumes.
- R7: For a program, the controller waits at least T_SETTLE cycles after the last confirming read and then reads the target address. `done` is reported if the word matches the request data, and `err` if it does not.
- R8: If polling has run POLL_LIMIT cycles without completing, the controller reports `err` at the next read boundary.
- R9: `req_ready` is high only when the controller is idle. It falls in the cycle after a request is accepted and rises in the cycle that `done` or `err` is pulsed. Requests presented while the controller is busy are not taken. `done` and `err` are single-cycle pulses and are never high together.
- R10: In reset, CE#, WE# and OE# are high, the data bus is not driven, `req_ready` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_op | input | 2 | 0 program, 1 sector erase, 2 or 3 chip erase |
| req_addr | input | 16 | Target word address or sector address |
| req_data | input | 16 | Word to program |
| done | output | 1 | One-cycle pulse: operation completed |
| err | output | 1 | One-cycle pulse: timeout or verify mismatch |
| fl_addr | output | 16 | Flash address bus |
| fl_dq_out | output | 16 | Flash data bus, outgoing value |
| fl_dq_oe | output | 1 | High while the controller drives the data bus |
| fl_dq_in | input | 16 | Flash data bus, incoming value |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench builds the controller with T_SETUP=2, T_PULSE=3, T_HOLD=1, T_SETTLE=20 and POLL_LIMIT=1500. With these values a stuck toggle bit reaches the timeout after a few hundred reads, and the settle gap before the verify read is large enough to measure against the gaps between ordinary polls. The distinct setup and pulse lengths let the bench catch a phase counter that is off by one. A flash model can be set to finish immediately, to finish after a chosen number of toggling reads, to pause its toggle once so that a false stable pair appears, to never finish, or to store a corrupted word.

// File: rtl/flashc_pkg.sv
package flashc_pkg;

    localparam int FL_AW = 16;
    localparam int FL_DW = 16;

    localparam logic [FL_AW-1:0] UNLOCK_A = 16'h5555;
    localparam logic [FL_AW-1:0] UNLOCK_B = 16'h2AAA;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2
    } fl_op_e;

    typedef enum logic [1:0] {
        B_IDLE, B_SETUP, B_PULSE, B_HOLD
    } bus_st_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_CMD_W, ST_RD, ST_RD_W, ST_SETTLE
    } ctl_st_e;

    typedef enum logic [2:0] {
        RP_FIRST, RP_POLL, RP_CONF1, RP_CONF2, RP_VER
    } rd_purpose_e;

    typedef struct packed {
        logic [FL_AW-1:0] addr;
        logic [FL_DW-1:0] data;
    } bus_word_t;

    function automatic logic [2:0] last_step(input fl_op_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

    function automatic bus_word_t cmd_word(input fl_op_e op, input logic [2:0] step,
                                           input logic [FL_AW-1:0] a,
                                           input logic [FL_DW-1:0] d);
        bus_word_t w;
        case (step)
            3'd0: w = '{UNLOCK_A, 16'h00AA};
            3'd1: w = '{UNLOCK_B, 16'h0055};
            3'd2: w = (op == OP_PROG) ? '{UNLOCK_A, 16'h00A0} : '{UNLOCK_A, 16'h0080};
            3'd3: w = (op == OP_PROG) ? '{a, d} : '{UNLOCK_A, 16'h00AA};
            3'd4: w = '{UNLOCK_B, 16'h0055};
            default: w = (op == OP_SECT) ? '{{a[15:11], 11'b0}, 16'h0030}
                                         : '{UNLOCK_A, 16'h0010};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/flashc_tmr.sv
module flashc_tmr #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign hit = (cnt >= CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && !hit)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flashc_bus.sv
module flashc_bus
    import flashc_pkg::*;
#(
    parameter int unsigned T_SETUP = 2,
    parameter int unsigned T_PULSE = 4,
    parameter int unsigned T_HOLD  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             go_wr,
    input  bus_word_t        go_word,
    output logic             fin,
    output logic [FL_DW-1:0] rd_word,
    output logic [FL_AW-1:0] fl_addr,
    output logic [FL_DW-1:0] fl_dq_out,
    output logic             fl_dq_oe,
    input  logic [FL_DW-1:0] fl_dq_in,
    output logic             fl_ce_n,
    output logic             fl_we_n,
    output logic             fl_oe_n
);
    localparam int unsigned TMAX = (T_SETUP > T_PULSE) ?
        ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
        ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CW  = $clog2(TMAX + 1);
    localparam int PWW = $clog2(T_PULSE + 2);

    bus_st_e   st;
    logic [CW-1:0] cnt;
    logic      wr_q;
    bus_word_t w_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= B_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            w_q     <= '0;
            rd_word <= '0;
        end else begin
            case (st)
                B_IDLE: if (go) begin
                    wr_q <= go_wr;
                    w_q  <= go_word;
                    cnt  <= CW'(T_SETUP - 1);
                    st   <= B_SETUP;
                end
                B_SETUP: if (cnt == '0) begin
                    cnt <= CW'(T_PULSE - 1);
                    st  <= B_PULSE;
                end else cnt <= cnt - 1'b1;
                B_PULSE: if (cnt == '0) begin
                    if (!wr_q) rd_word <= fl_dq_in;
                    cnt <= CW'(T_HOLD - 1);
                    st  <= B_HOLD;
                end else cnt <= cnt - 1'b1;
                default: if (cnt == '0) st <= B_IDLE;
                         else cnt <= cnt - 1'b1;
            endcase
        end
    end

    assign fin       = (st == B_HOLD) && (cnt == '0);
    assign fl_addr   = w_q.addr;
    assign fl_dq_out = w_q.data;
    assign fl_dq_oe  = wr_q && (st != B_IDLE);
    assign fl_ce_n   = (st == B_IDLE);
    assign fl_we_n   = !((st == B_PULSE) && wr_q);
    assign fl_oe_n   = !((st == B_PULSE) && !wr_q);

    // Independent low-time counter for the write strobe
    logic [PWW-1:0] we_lo;
    always_ff @(posedge clk) begin
        if (rst || fl_we_n) we_lo <= '0;
        else                we_lo <= we_lo + 1'b1;
    end

    assert_ce_under_we_R4: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));
    assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (we_lo == PWW'(T_PULSE)));
    assert_strobe_idle_R10: assert property (@(posedge clk) disable iff (rst)
        fl_ce_n |-> (fl_we_n && fl_oe_n && !fl_dq_oe));
endmodule

// File: rtl/flashc_top.sv
module flashc_top
    import flashc_pkg::*;
#(
    parameter int unsigned T_SETUP    = 2,
    parameter int unsigned T_PULSE    = 4,
    parameter int unsigned T_HOLD     = 2,
    parameter int unsigned T_SETTLE   = 200,
    parameter int unsigned POLL_LIMIT = 40_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_data,
    output logic        done,
    output logic        err,
    output logic [15:0] fl_addr,
    output logic [15:0] fl_dq_out,
    output logic        fl_dq_oe,
    input  logic [15:0] fl_dq_in,
    output logic        fl_ce_n,
    output logic        fl_we_n,
    output logic        fl_oe_n
);
    ctl_st_e     st;
    rd_purpose_e rp;
    fl_op_e      op_q;
    logic [FL_AW-1:0] addr_q;
    logic [FL_DW-1:0] data_q;
    logic [2:0]  step_q;
    logic        prev_q, done_q, err_q, cmds_done;

    logic        bus_go, bus_fin, to_hit, settle_hit, accept, b6;
    logic [FL_DW-1:0] rd_word;
    bus_word_t   bus_word;

    assign accept    = req_valid && (st == ST_IDLE);
    assign req_ready = (st == ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign b6        = rd_word[6];

    assign bus_go   = (st == ST_CMD) ||
                      ((st == ST_RD) && !((rp != RP_VER) && to_hit));
    assign bus_word = (st == ST_CMD) ? cmd_word(op_q, step_q, addr_q, data_q)
                                     : '{addr_q, 16'h0000};

    flashc_bus #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) bus_i (
        .clk, .rst, .go(bus_go), .go_wr(st == ST_CMD), .go_word(bus_word),
        .fin(bus_fin), .rd_word,
        .fl_addr, .fl_dq_out, .fl_dq_oe, .fl_dq_in,
        .fl_ce_n, .fl_we_n, .fl_oe_n
    );

    flashc_tmr #(.LIMIT(POLL_LIMIT)) poll_tmr_i (
        .clk, .rst, .clr(accept),
        .en(((st == ST_RD) || (st == ST_RD_W)) && (rp != RP_VER)),
        .hit(to_hit)
    );

    flashc_tmr #(.LIMIT(T_SETTLE)) settle_tmr_i (
        .clk, .rst, .clr(st != ST_SETTLE), .en(1'b1), .hit(settle_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            rp     <= RP_FIRST;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            step_q <= '0;
            prev_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st)
                ST_IDLE: if (accept) begin
                    op_q   <= (req_op == 2'd3) ? OP_CHIP : fl_op_e'(req_op);
                    addr_q <= req_addr;
                    data_q <= req_data;
                    step_q <= '0;
                    st     <= ST_CMD;
                end
                ST_CMD: st <= ST_CMD_W;
                ST_CMD_W: if (bus_fin) begin
                    if (step_q == last_step(op_q)) begin
                        rp <= RP_FIRST;
                        st <= ST_RD;
                    end else begin
                        step_q <= step_q + 1'b1;
                        st     <= ST_CMD;
                    end
                end
                ST_RD: if ((rp != RP_VER) && to_hit) begin
                    err_q <= 1'b1;
                    st    <= ST_IDLE;
                end else st <= ST_RD_W;
                ST_RD_W: if (bus_fin) begin
                    st <= ST_RD;
                    case (rp)
                        RP_FIRST: begin prev_q <= b6; rp <= RP_POLL; end
                        RP_POLL:  if (b6 == prev_q) rp <= RP_CONF1;
                                  else prev_q <= b6;
                        RP_CONF1: if (b6 == prev_q) rp <= RP_CONF2;
                                  else begin prev_q <= b6; rp <= RP_POLL; end
                        RP_CONF2: if (b6 != prev_q) begin
                                      prev_q <= b6; rp <= RP_POLL;
                                  end else if (op_q == OP_PROG) st <= ST_SETTLE;
                                  else begin done_q <= 1'b1; st <= ST_IDLE; end
                        default: begin
                            done_q <= (rd_word == data_q);
                            err_q  <= (rd_word != data_q);
                            st     <= ST_IDLE;
                        end
                    endcase
                end
                ST_SETTLE: if (settle_hit) begin
                    rp <= RP_VER;
                    st <= ST_RD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Marks that the final command write of the current request has ended
    always_ff @(posedge clk) begin
        if (rst || accept) cmds_done <= 1'b0;
        else if ((st == ST_CMD_W) && bus_fin && (step_q == last_step(op_q)))
            cmds_done <= 1'b1;
    end

    assert_no_early_read_R5: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> cmds_done);
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    assert_result_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (done || err) |=> !(done || err));
endmodule

// File: tb/flashc_top_tb_top.sv
`timescale 1ns/1ps
module flashc_top_tb_top;
    localparam int TS = 2, TP = 3, TH = 1, TSET = 20, PLIM = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [15:0] req_addr = '0, req_data = '0;
    logic req_ready, done, err, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
    logic [15:0] fl_addr, fl_dq_out, fl_dq_in;

    always #2.5 clk = ~clk;

    flashc_top #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
                 .T_SETTLE(TSET), .POLL_LIMIT(PLIM)) dut_i (
        .clk, .rst, .req_valid, .req_ready, .req_op, .req_addr, .req_data,
        .done, .err, .fl_addr, .fl_dq_out, .fl_dq_oe, .fl_dq_in,
        .fl_ce_n, .fl_we_n, .fl_oe_n
    );

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Scoreboard of expected bus writes
    logic [15:0] exp_a[$];
    logic [15:0] exp_d[$];
    string       exp_t[$];

    // Flash model configuration and state
    int  n_wr, wr_cnt, busy_left, fake_idx, busy_rd_idx, post_reads;
    bit  busy, tog, stuck, early_rd;
    logic [15:0] word;
    logic b7;
    int  cyc_n, last_wr_cyc, last_rise_cyc, last_gap;
    logic [15:0] last_rd_addr;
    logic prev_we = 1'b1, prev_oe = 1'b1;
    int  we_lo, setup_cnt;

    always_comb fl_dq_in = busy ? {8'h00, b7, tog, 6'h00} : word;

    always @(negedge clk) begin
        cyc_n++;
        if (!rst) begin
            if (fl_ce_n) setup_cnt = 0;
            else if (fl_we_n && fl_oe_n && prev_we) setup_cnt++;
            if (!fl_we_n) we_lo++;
            if (prev_we && !fl_we_n) begin
                chk(setup_cnt == TS + 1 - 1, "R4", "setup before WE# fall", setup_cnt, TS);
                chk(!fl_ce_n && fl_oe_n && fl_dq_oe, "R4", "CE#/OE#/drive during WE#",
                    {fl_ce_n, fl_oe_n, fl_dq_oe}, 3'b011);
            end
            if (!prev_we && fl_we_n) begin
                chk(we_lo == TP, "R4", "WE# low width", we_lo, TP);
                we_lo = 0;
                if (exp_a.size() == 0)
                    chk(1'b0, "R9", "unexpected bus write", {fl_addr, fl_dq_out}, 0);
                else begin
                    logic [15:0] ea, ed;
                    string et;
                    ea = exp_a.pop_front(); ed = exp_d.pop_front(); et = exp_t.pop_front();
                    chk(fl_addr == ea && fl_dq_out == ed, et, "bus write addr/data",
                        {fl_addr, fl_dq_out}, {ea, ed});
                end
                wr_cnt++;
                last_wr_cyc = cyc_n;
                if (wr_cnt == n_wr) begin
                    busy = (busy_left > 0) || stuck;
                    tog = 1'b0;
                    busy_rd_idx = 0;
                end
            end
            if (prev_oe && !fl_oe_n) begin
                if (wr_cnt < n_wr) early_rd = 1'b1;
                last_gap = cyc_n - last_rise_cyc;
                last_rd_addr = fl_addr;
            end
            if (!prev_oe && fl_oe_n) begin
                last_rise_cyc = cyc_n;
                if (busy) begin
                    if (busy_rd_idx != fake_idx) tog = ~tog;
                    busy_rd_idx++;
                    if (!stuck) begin
                        busy_left--;
                        if (busy_left == 0) busy = 1'b0;
                    end
                end else post_reads++;
            end
        end
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    task automatic push_w(input logic [15:0] a, input logic [15:0] d, input string t);
        exp_a.push_back(a); exp_d.push_back(d); exp_t.push_back(t);
    endtask

    // op: 0 program, 1 sector, 2 chip; mode: 0 normal, 1 fake pair, 2 stuck, 3 corrupt
    task automatic do_req(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                          input int breads, input int mode, input bit nag, input bit exp_err);
        string rt;
        int    wait_n;
        rt = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
        n_wr = (op == 0) ? 4 : 6;
        wr_cnt = 0; busy = 1'b0; busy_left = breads; post_reads = 0; early_rd = 1'b0;
        fake_idx = (mode == 1) ? 1 : -1;
        stuck = (mode == 2);
        word = (op == 0) ? (d ^ ((mode == 3) ? 16'h0100 : 16'h0000)) : 16'hFFFF;
        b7 = (op == 0) ? ~d[7] : 1'b0;
        push_w(16'h5555, 16'h00AA, rt);
        push_w(16'h2AAA, 16'h0055, rt);
        if (op == 0) begin
            push_w(16'h5555, 16'h00A0, rt);
            push_w(a, d, rt);
        end else begin
            push_w(16'h5555, 16'h0080, rt);
            push_w(16'h5555, 16'h00AA, rt);
            push_w(16'h2AAA, 16'h0055, rt);
            if (op == 1) push_w({a[15:11], 11'b0}, 16'h0030, rt);
            else         push_w(16'h5555, 16'h0010, rt);
        end
        @(negedge clk);
        chk(req_ready, "R9", "ready while idle", req_ready, 1);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(posedge clk);
        @(negedge clk);
        chk(!req_ready, "R9", "ready low after accept", req_ready, 0);
        if (nag) begin
            req_op = 2'd2; req_addr = 16'h0000; req_data = 16'h0000;
        end else req_valid = 1'b0;
        wait_n = 0;
        while (!(done || err) && wait_n < 20000) begin
            if (wait_n == 10) chk(!req_ready, "R9", "ready low while busy", req_ready, 0);
            @(negedge clk);
            wait_n++;
        end
        req_valid = 1'b0;
        chk(done != exp_err && err == exp_err, exp_err ? "R7/R8" : "R6",
            "result done/err", {done, err}, {!exp_err, exp_err});
        chk(req_ready, "R9", "ready with result", req_ready, 1);
        chk(exp_a.size() == 0, rt, "command writes remaining", exp_a.size(), 0);
        chk(!early_rd, "R5", "read before last command write", early_rd, 0);
        if (!exp_err) begin
            chk(!busy, "R6", "done while flash busy", busy, 0);
            chk(post_reads >= 2, "R6", "confirm reads after finish", post_reads, 2);
        end
        if (op == 0 && mode != 2) begin
            chk(last_gap >= TSET, "R7", "settle gap before verify", last_gap, TSET);
            chk(last_rd_addr == a, "R7", "verify address", last_rd_addr, a);
        end
        if (mode == 2) begin
            chk((cyc_n - last_wr_cyc) >= PLIM && (cyc_n - last_wr_cyc) <= PLIM + 40,
                "R8", "timeout latency", cyc_n - last_wr_cyc, PLIM);
        end
        @(negedge clk);
        chk(!done && !err, "R9", "single-cycle result", {done, err}, 0);
        exp_a.delete(); exp_d.delete(); exp_t.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R10", "bus idle in reset",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
        chk(req_ready && !done && !err, "R10", "handshake in reset",
            {req_ready, done, err}, 3'b100);
        rst = 1'b0;
        do_req(2'd0, 16'h1234, 16'hA55A, 5, 0, 1'b0, 1'b0);   // R1 R6 R7
        do_req(2'd0, 16'hFFFF, 16'h0040, 0, 0, 1'b1, 1'b0);   // R1 R9 immediate finish
        do_req(2'd1, 16'hBCDE, 16'h0000, 7, 0, 1'b0, 1'b0);   // R2
        do_req(2'd2, 16'h0123, 16'h0000, 3, 0, 1'b0, 1'b0);   // R3
        do_req(2'd3, 16'h0777, 16'h0000, 2, 0, 1'b0, 1'b0);   // R3 opcode 3 alias
        do_req(2'd0, 16'h4000, 16'h00C3, 8, 1, 1'b0, 1'b0);   // R6 false stable pair
        do_req(2'd0, 16'h0AB0, 16'h5A5A, 4, 3, 1'b0, 1'b1);   // R7 mismatch
        do_req(2'd1, 16'h8800, 16'h0000, 0, 2, 1'b0, 1'b1);   // R8 timeout
        do_req(2'd0, 16'h0002, 16'hFFFE, 2, 0, 1'b0, 1'b0);   // recovery
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule